// File: doc/BRIEF.md
# Message-Add Stage for the Second Ciphertext Polynomial

This block completes the second ciphertext polynomial of a module-lattice key-encapsulation encryptor. An earlier part of the datapath has already left two things in the partial-sum bank: a partial sum in one slot, and an error polynomial in another. The block then runs two passes over all N = 256 coefficients. The first pass moves the error polynomial into a slot of a second coefficient bank. The second pass reads the partial sum and the moved error together, adds the message term, reduces the result modulo q = 3329, and writes it back over the partial sum.

Each bank has one read port and one write port, and a read returns its data one cycle after the address is given. The move exists so that the add pass can fetch both stored operands in the same cycle from two different banks. During the move, each write goes out in the same cycle as the read data it carries, and it uses that data's own index.

The surrounding controller pulses `start` once the earlier ciphertext and decode work has finished. It then waits for `done`, after which the updated slot holds the finished polynomial.

Top module: `msg_add_stage`

## Requirements
- R1: While reset is held and after it is released with no start, `done`, `p_wr_en` and `s_wr_en` are all low.
- R2: After a run, for every w in 0..255, coefficient w of second-bank slot DST_SLOT (default 1, address DST_SLOT*256+w) equals coefficient w of partial-sum-bank slot ERR_SLOT (default 0) as it was at start. No coefficient is shifted to a neighbouring index.
- R3: Every write to the second bank happens exactly one cycle after the partial-sum-bank read of the same index in slot ERR_SLOT, and it carries that read's data.
- R4: After a run, coefficient w of partial-sum-bank slot PSUM_SLOT (default 1) equals (psum[w] + e[w] + mu[w]) mod 3329, where mu[w] = 1665 when msg[w] is 1 and 0 when it is 0.
- R5: Reduction is exact at the edges of the range. A sum of exactly 3329 gives 0, the largest sum 3328+3328+1665 gives 1663, and a sum of 3328 stays 3328. Every written value is below 3329.
- R6: A run changes only PSUM_SLOT of the partial-sum bank and DST_SLOT of the second bank. The source slot ERR_SLOT and every other slot keep their contents.
- R7: All 256 move writes finish before the first write-back. Write-backs never overlap move writes, and each write-back uses operands read one cycle earlier at the same index from PSUM_SLOT and from second-bank slot DST_SLOT.
- R8: `done` is high for exactly one cycle. It rises 2*256+1 = 513 clock edges after the edge that accepts `start`, which is the cycle after the last write-back.
- R9: A `start` pulse that arrives while a run is in progress is ignored. The run keeps its timing and its results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a run |
| msg | input | 256 | Message bits, bit w encodes coefficient w |
| p_rd_addr | output | 10 | Partial-sum bank read address (slot*256+index) |
| p_rd_data | input | 12 | Partial-sum bank read data, one cycle after address |
| p_wr_en | output | 1 | Partial-sum bank write enable |
| p_wr_addr | output | 10 | Partial-sum bank write address |
| p_wr_data | output | 12 | Partial-sum bank write data |
| s_rd_addr | output | 10 | Second bank read address |
| s_rd_data | input | 12 | Second bank read data, one cycle after address |
| s_wr_en | output | 1 | Second bank write enable |
| s_wr_addr | output | 10 | Second bank write address |
| s_wr_data | output | 12 | Second bank write data |
| done | output | 1 | One-cycle completion pulse |

## Verification
If the write index slips one step against the read latency, the moved polynomial comes out rotated by one position. That first appears as a wrong value in the second bank one cycle after the move write. It spreads into every output coefficient by the end of the run. A fault in the phase or counter state moves the `done` pulse away from edge 513, or lets a stray start restart the move, and that restart then adds the message twice to coefficients already finished. A fault in the reduction shows up as an out-of-range or wrong value on `p_wr_data` in the very cycle of the write-back, and the edge-case coefficients are placed to expose it.

// File: rtl/msg_add_stage.sv
module msg_add_stage #(
  parameter int N         = 256,
  parameter int W         = 12,
  parameter int Q         = 3329,
  parameter int P_SLOTS   = 4,
  parameter int S_SLOTS   = 4,
  parameter int ERR_SLOT  = 0,
  parameter int PSUM_SLOT = 1,
  parameter int DST_SLOT  = 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start,
  input  logic [N-1:0]                 msg,
  output logic [$clog2(P_SLOTS*N)-1:0] p_rd_addr,
  input  logic [W-1:0]                 p_rd_data,
  output logic                         p_wr_en,
  output logic [$clog2(P_SLOTS*N)-1:0] p_wr_addr,
  output logic [W-1:0]                 p_wr_data,
  output logic [$clog2(S_SLOTS*N)-1:0] s_rd_addr,
  input  logic [W-1:0]                 s_rd_data,
  output logic                         s_wr_en,
  output logic [$clog2(S_SLOTS*N)-1:0] s_wr_addr,
  output logic [W-1:0]                 s_wr_data,
  output logic                         done
);
  localparam int IW  = $clog2(N);
  localparam int PAW = $clog2(P_SLOTS*N);
  localparam int SAW = $clog2(S_SLOTS*N);
  localparam int SW  = W + 2;
  localparam int MU  = (Q + 1) / 2;
  localparam logic [IW-1:0]  LAST      = IW'(N - 1);
  localparam logic [PAW-1:0] ERR_BASE  = PAW'(ERR_SLOT * N);
  localparam logic [PAW-1:0] PSUM_BASE = PAW'(PSUM_SLOT * N);
  localparam logic [SAW-1:0] DST_BASE  = SAW'(DST_SLOT * N);

  typedef enum logic [1:0] {IDLE, MOVE, ADD} phase_t;

  phase_t        st;
  logic [IW-1:0] idx, idx_q;
  logic          mv_v, ad_v, done_q;
  logic [SW-1:0] sum3, red1, red2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= IDLE;
      idx    <= '0;
      idx_q  <= '0;
      mv_v   <= 1'b0;
      ad_v   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      mv_v   <= (st == MOVE);
      ad_v   <= (st == ADD);
      idx_q  <= idx;
      done_q <= ad_v && (idx_q == LAST);
      unique case (st)
        IDLE: if (start && !ad_v) begin
          st  <= MOVE;
          idx <= '0;
        end
        MOVE: begin
          idx <= (idx == LAST) ? '0 : idx + 1'b1;
          if (idx == LAST) st <= ADD;
        end
        ADD: begin
          idx <= (idx == LAST) ? '0 : idx + 1'b1;
          if (idx == LAST) st <= IDLE;
        end
        default: st <= IDLE;
      endcase
    end
  end

  assign p_rd_addr = ((st == ADD) ? PSUM_BASE : ERR_BASE) | PAW'(idx);
  assign s_rd_addr = DST_BASE | SAW'(idx);

  assign s_wr_en   = mv_v;
  assign s_wr_addr = DST_BASE | SAW'(idx_q);
  assign s_wr_data = p_rd_data;

  assign sum3 = SW'(p_rd_data) + SW'(s_rd_data) + (msg[idx_q] ? SW'(MU) : SW'(0));
  assign red1 = (sum3 >= SW'(Q)) ? sum3 - SW'(Q) : sum3;
  assign red2 = (red1 >= SW'(Q)) ? red1 - SW'(Q) : red1;

  assign p_wr_en   = ad_v;
  assign p_wr_addr = PSUM_BASE | PAW'(idx_q);
  assign p_wr_data = red2[W-1:0];
  assign done      = done_q;

  // R1
  idle_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !done && !p_wr_en && !s_wr_en);

  // R3
  move_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_wr_en |-> (s_wr_addr[IW-1:0] == $past(p_rd_addr[IW-1:0]))
             && ($past(p_rd_addr[PAW-1:IW]) == (PAW-IW)'(ERR_SLOT))
             && (s_wr_addr[SAW-1:IW] == (SAW-IW)'(DST_SLOT)));

  // R7
  add_operands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    p_wr_en |-> ($past(p_rd_addr) == p_wr_addr)
             && ($past(s_rd_addr[IW-1:0]) == p_wr_addr[IW-1:0])
             && ($past(s_rd_addr[SAW-1:IW]) == (SAW-IW)'(DST_SLOT)));

  // R7
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    p_wr_en |-> !s_wr_en);

  // R5
  reduced_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    p_wr_en |-> (p_wr_data < W'(Q)));

  // R8
  done_after_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(p_wr_en) && !p_wr_en && !s_wr_en);

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: tb/tb_msg_add_stage.sv
module tb_msg_add_stage;
  localparam int PERIOD = 10;
  localparam int N = 256;
  localparam int Q = 3329;
  localparam int DEPTH = 1024;
  localparam int ERR = 0, PS = 256, DST = 256;
  localparam int NV = 8;
  // psum, err, msg bit, expected
  localparam int TBL [NV][4] = '{
    '{0, 0, 0, 0},
    '{3328, 3328, 1, 1663},
    '{1664, 0, 1, 0},
    '{1663, 0, 1, 3328},
    '{3328, 1, 0, 0},
    '{3328, 0, 0, 3328},
    '{0, 0, 1, 1665},
    '{2000, 1329, 0, 0}
  };

  logic clk = 0, rst_n = 0, start = 0;
  logic [N-1:0] msg = '0;
  logic [9:0] p_rd_addr, p_wr_addr, s_rd_addr, s_wr_addr;
  logic [11:0] p_rd_data, p_wr_data, s_rd_data, s_wr_data;
  logic p_wr_en, s_wr_en, done;

  logic [11:0] pm [DEPTH], sm [DEPTH], pref [DEPTH], sref [DEPTH];
  int checks = 0, fails = 0, cyc = 0;
  int n_s, n_p, last_s, first_p, n_done;

  always #(PERIOD/2) clk = ~clk;

  msg_add_stage dut (.clk(clk), .rst_n(rst_n), .start(start), .msg(msg),
    .p_rd_addr(p_rd_addr), .p_rd_data(p_rd_data), .p_wr_en(p_wr_en),
    .p_wr_addr(p_wr_addr), .p_wr_data(p_wr_data), .s_rd_addr(s_rd_addr),
    .s_rd_data(s_rd_data), .s_wr_en(s_wr_en), .s_wr_addr(s_wr_addr),
    .s_wr_data(s_wr_data), .done(done));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    p_rd_data <= pm[p_rd_addr];
    s_rd_data <= sm[s_rd_addr];
    if (p_wr_en) begin
      pm[p_wr_addr] <= p_wr_data;
      n_p <= n_p + 1;
      if (first_p < 0) first_p <= cyc;
    end
    if (s_wr_en) begin
      sm[s_wr_addr] <= s_wr_data;
      n_s <= n_s + 1;
      last_s <= cyc;
    end
    if (done) n_done <= n_done + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic fill_random();
    for (int a = 0; a < DEPTH; a++) begin
      pm[a] = 12'($urandom % Q);
      sm[a] = 12'($urandom % Q);
    end
  endtask

  task automatic run(input bit poke_busy);
    int lat, bad_p, bad_s, first_bad;
    for (int a = 0; a < DEPTH; a++) begin
      pref[a] = pm[a];
      sref[a] = sm[a];
    end
    for (int w = 0; w < N; w++) begin
      sref[DST + w] = pm[ERR + w];
      pref[PS + w] = 12'((int'(pm[PS + w]) + int'(pm[ERR + w]) + (msg[w] ? 1665 : 0)) % Q);
    end
    n_s = 0; n_p = 0; last_s = -1; first_p = -1; n_done = 0;
    @(negedge clk); start = 1;
    @(posedge clk);
    @(negedge clk); start = 0;
    lat = 1;
    while (!done && lat < 2000) begin
      @(posedge clk); #1;
      if (!done) lat++;
      if (poke_busy && (lat == 100 || lat == 400)) begin
        @(negedge clk); start = 1; @(negedge clk); start = 0; lat += 1;
      end
    end
    // R8 latency and pulse width
    chk(lat == 2*N + 1, "R8 done latency", lat, 2*N + 1);
    @(posedge clk); #1;
    chk(!done, "R8 done one cycle", int'(done), 0);
    repeat (3) @(posedge clk);
    #1;
    chk(n_done == 1, poke_busy ? "R9 single done under busy start" : "R8 done count", n_done, 1);
    // R7 order and counts
    chk(n_s == N && n_p == N, "R7 write counts", n_s * 1000 + n_p, N * 1000 + N);
    chk(first_p > last_s, "R7 add after move", first_p, last_s + 1);
    // R2 relocation
    bad_s = 0; first_bad = -1;
    for (int w = 0; w < N; w++)
      if (sm[DST + w] !== sref[DST + w]) begin bad_s++; if (first_bad < 0) first_bad = w; end
    chk(bad_s == 0, "R2 relocated slot", first_bad, -1);
    // R4 results
    bad_p = 0; first_bad = -1;
    for (int w = 0; w < N; w++)
      if (pm[PS + w] !== pref[PS + w]) begin bad_p++; if (first_bad < 0) first_bad = w; end
    chk(bad_p == 0, poke_busy ? "R9 results under busy start" : "R4 message add", first_bad, -1);
    // R6 untouched slots
    bad_p = 0;
    for (int a = 0; a < DEPTH; a++)
      if ((a < PS || a >= PS + N) && pm[a] !== pref[a]) bad_p++;
    bad_s = 0;
    for (int a = 0; a < DEPTH; a++)
      if ((a < DST || a >= DST + N) && sm[a] !== sref[a]) bad_s++;
    chk(bad_p == 0 && bad_s == 0, "R6 other slots kept", bad_p + bad_s, 0);
  endtask

  initial begin
    #(PERIOD * 200000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    fill_random();
    repeat (3) @(posedge clk);
    #1;
    chk(!done && !p_wr_en && !s_wr_en, "R1 in reset", int'({done, p_wr_en, s_wr_en}), 0);
    @(negedge clk); rst_n = 1;
    repeat (4) @(posedge clk);
    #1;
    chk(!done && !p_wr_en && !s_wr_en, "R1 idle after reset", int'({done, p_wr_en, s_wr_en}), 0);

    // table walk: edge-case coefficients placed at the low indices and at the top index
    fill_random();
    for (int w = 0; w < N; w++) msg[w] = 1'($urandom);
    for (int k = 0; k < NV; k++) begin
      pm[PS + k]  = 12'(TBL[k][0]);
      pm[ERR + k] = 12'(TBL[k][1]);
      msg[k]      = 1'(TBL[k][2]);
    end
    pm[PS + N - 1] = 12'(3328); pm[ERR + N - 1] = 12'(3328); msg[N - 1] = 1'b1;
    run(1'b0);
    for (int k = 0; k < NV; k++)
      chk(pm[PS + k] == 12'(TBL[k][3]), "R5 table entry", int'(pm[PS + k]), TBL[k][3]);
    chk(pm[PS + N - 1] == 12'(1663), "R5 top index max sum", int'(pm[PS + N - 1]), 1663);

    // all-ones message, fresh data
    fill_random();
    msg = '1;
    run(1'b0);

    // all-zeros message, with starts poked while busy
    fill_random();
    msg = '0;
    run(1'b1);

    // alternating message, back-to-back run on fresh data
    fill_random();
    for (int w = 0; w < N; w++) msg[w] = 1'(w % 2);
    run(1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule